// File: doc/BRIEF.md
# Double-Buffered Configuration Registers with Update Strobe

This block is a configuration register file whose writes never reach the logic that uses them directly. Every write lands in a shadow buffer. The whole set of buffers is copied into the active registers at once, on a single update event. Downstream logic therefore sees a new set of settings change on one clock edge, never a half-written mix.

The update event has one of two sources, and a mode bit held in the register file chooses between them. In internal mode, a free-running down-counter fires an event every period-plus-one cycles, and the update pin is driven as an output that goes high for eight cycles at each commit. In external mode, the pin is an input: it is synchronised, and each rising edge commits the buffers.

A synchronous reset restores every active register and every buffer to inert defaults. The data registers return to zero, the mode returns to internal, and the period returns to a parameter value.

Top module: `dbuf_cfg_regs`

## Requirements
- R1: A write (wr_en high at a rising clock edge) changes only the shadow buffer at wr_addr. The value on regs_o changes only on a commit edge, and between commits regs_o holds steady.
- R2: Address map. Addresses 0 to NUM_REGS-1 are data registers, with register k on regs_o[k*REG_W +: REG_W]. Address NUM_REGS is the mode register, and bit 0 of it selects the mode: 1 = internal mode with the pin as an output, 0 = external mode with the pin as an input. Address NUM_REGS+1 is the period register, loaded from the low bits of wr_data and zero-extended. A write to any other address changes nothing.
- R3: rst_n low at a rising edge sets every data register (active and buffered) to 0, the mode to internal (upd_oe = 1), the period to DEF_PERIOD, and upd_out to 0.
- R4: In internal mode the counter fires every P+1 cycles, where P is the active period. Take the first edge with rst_n high as edge 0: the first commit after reset lands on edge DEF_PERIOD+1. A commit lands two edges after the edge on which the counter reaches zero.
- R5: Each internal commit drives upd_out high for PULSE_LEN (8) cycles, starting right after the commit edge. A further commit during a pulse restarts the full length.
- R6: upd_oe equals the active mode bit. upd_out is 0 whenever the active mode is external.
- R7: In external mode, suppose upd_in is first seen high at rising edge k. The commit then lands on edge k+2. A falling edge, or a level held high, commits nothing.
- R8: In internal mode upd_in has no effect. In external mode the counter's events commit nothing.
- R9: A write captured on the same edge as a commit is not part of that commit. It is applied at the following commit.
- R10: Mode and period writes take effect only when committed. A newly committed period is first loaded at the counter's next reload, after the count already in progress has run out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | ADDR_W | Buffer write address |
| wr_data | input | REG_W | Buffer write data |
| upd_in | input | 1 | Update pin as sampled from the pad (asynchronous) |
| upd_out | output | 1 | Update pin drive value (commit pulse) |
| upd_oe | output | 1 | Update pin output enable (1 = internal mode) |
| regs_o | output | NUM_REGS*REG_W | Active data register values |

## Verification
The bench builds the block with NUM_REGS=3, REG_W=16 and DEF_PERIOD=15. A short default period lets the first internal commits, and their eight-cycle pulses, land within a few dozen cycles of reset. With three data registers and a 3-bit address, addresses 5 to 7 are unused, so the ignore rule for out-of-map writes can be exercised. A committed period of 5 makes commits come closer together than the pulse length, which exercises the retrigger. The run then switches to external mode and back, covering the three-edge pin latency, the hold and falling-edge cases, and the reload-deferred period change.

// File: rtl/dbuf_pkg.sv
`timescale 1ns/1ps
// dbuf_pkg: types shared by the double-buffered register file.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dbuf_pkg;

    // Source of commit events; encoding matches bit 0 of the mode register.
    typedef enum logic {
        MODE_EXT = 1'b0,   // update pin is an input, its rising edge commits
        MODE_INT = 1'b1    // internal counter commits, pin reports pulses
    } upd_mode_e;

endpackage

// File: rtl/dbuf_edge_sync.sv
`timescale 1ns/1ps
// dbuf_edge_sync: brings an asynchronous pin into the clock domain through
// SYNC_STAGES flops, then flags its rising edge for one cycle.
// Assumes: the pin stays at each level for at least two clock periods.
module dbuf_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    // Synchronizer stages plus one history flop for edge detection.
    logic [SYNC_STAGES:0] chain_q;

    // Shift the pin through the synchronizer and history flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-1:0], pin_i};
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R7

endmodule

// File: rtl/dbuf_upd_timer.sv
`timescale 1ns/1ps
// dbuf_upd_timer: free-running down-counter that raises a one-cycle tick
// every period_i+1 cycles. It reloads from period_i when it reaches zero,
// so a new period is first used at the reload after the count in progress.
// Assumes: period_i comes from the active (committed) register.
module dbuf_upd_timer #(
    parameter int          CNT_W      = 32,
    parameter int unsigned DEF_PERIOD = 1023
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;

    // Count down; on zero reload and register the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_W'(DEF_PERIOD);
            tick_q <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= period_i;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - CNT_W'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    AST_TICK_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> !tick_o); // R4

endmodule

// File: rtl/dbuf_pulse_gen.sv
`timescale 1ns/1ps
// dbuf_pulse_gen: retriggerable pulse stretcher. A fire input starts a
// PULSE_LEN-cycle high output; firing again restarts the full length.
// Assumes: PULSE_LEN >= 1.
module dbuf_pulse_gen #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);

    localparam int LEN_W = $clog2(PULSE_LEN + 1);

    logic [LEN_W-1:0] left_q;

    // Load the length on fire, otherwise count the remaining cycles down.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (fire_i)         left_q <= LEN_W'(PULSE_LEN);
        else if (left_q != '0)   left_q <= left_q - LEN_W'(1);
    end

    assign pulse_o = (left_q != '0);

    AST_PULSE_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> pulse_o); // R5

endmodule

// File: rtl/dbuf_reg_bank.sv
`timescale 1ns/1ps
// dbuf_reg_bank: shadow buffers and active copies for the data registers,
// the mode bit and the update period. Writes touch buffers only; commit_i
// copies every buffer to its active register on the same edge.
// Assumes: ADDR_W can hold NUM_REGS+1; unmapped addresses are ignored.
module dbuf_reg_bank
    import dbuf_pkg::*;
#(
    parameter int          NUM_REGS   = 4,
    parameter int          REG_W      = 32,
    parameter int          CNT_W      = 32,
    parameter int unsigned DEF_PERIOD = 1023,
    parameter int          ADDR_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic                      commit_i,
    output logic [NUM_REGS*REG_W-1:0] data_o,
    output upd_mode_e                 mode_o,
    output logic [CNT_W-1:0]          period_o
);

    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] PER_ADDR  = ADDR_W'(NUM_REGS + 1);

    logic [CNT_W-1:0] per_wdata;

    // Fit the write data to the period width.
    generate
        if (REG_W >= CNT_W) begin : g_per_trunc
            assign per_wdata = wr_data[CNT_W-1:0];
        end else begin : g_per_ext
            assign per_wdata = {{(CNT_W-REG_W){1'b0}}, wr_data};
        end
    endgenerate

    // One buffer/active pair per data register.
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_data
            logic [REG_W-1:0] buf_q;
            logic [REG_W-1:0] act_q;

            // Capture writes addressed to this register.
            always_ff @(posedge clk) begin
                if (!rst_n)                                     buf_q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(i))        buf_q <= wr_data;
            end

            // Copy the buffer into the active register on commit.
            always_ff @(posedge clk) begin
                if (!rst_n)        act_q <= '0;
                else if (commit_i) act_q <= buf_q;
            end

            assign data_o[i*REG_W +: REG_W] = act_q;
        end
    endgenerate

    upd_mode_e        mode_buf_q, mode_act_q;
    logic [CNT_W-1:0] per_buf_q,  per_act_q;

    // Capture writes to the mode and period buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_buf_q <= MODE_INT;
            per_buf_q  <= CNT_W'(DEF_PERIOD);
        end else if (wr_en) begin
            if (wr_addr == MODE_ADDR) mode_buf_q <= upd_mode_e'(wr_data[0]);
            if (wr_addr == PER_ADDR)  per_buf_q  <= per_wdata;
        end
    end

    // Commit the mode and period buffers together with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_act_q <= MODE_INT;
            per_act_q  <= CNT_W'(DEF_PERIOD);
        end else if (commit_i) begin
            mode_act_q <= mode_buf_q;
            per_act_q  <= per_buf_q;
        end
    end

    assign mode_o   = mode_act_q;
    assign period_o = per_act_q;

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(data_o) && $stable(mode_o) && $stable(period_o))); // R1

endmodule

// File: rtl/dbuf_cfg_regs.sv
`timescale 1ns/1ps
// dbuf_cfg_regs: double-buffered configuration register file. Commits
// come from the internal period timer (internal mode, pin driven with an
// eight-cycle pulse per commit) or from rising edges on the synchronised
// update pin (external mode). The pad itself is outside this block.
// Assumes: upd_in is asynchronous; the pad uses upd_oe/upd_out.
module dbuf_cfg_regs
    import dbuf_pkg::*;
#(
    parameter int          NUM_REGS    = 4,
    parameter int          REG_W       = 32,
    parameter int          CNT_W       = 32,
    parameter int unsigned DEF_PERIOD  = 1023,
    parameter int          PULSE_LEN   = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = $clog2(NUM_REGS + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic                      upd_in,
    output logic                      upd_out,
    output logic                      upd_oe,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    upd_mode_e        mode;
    logic [CNT_W-1:0] period;
    logic             tick;
    logic             pin_rise;
    logic             commit_int;
    logic             commit_ext;
    logic             commit;
    logic             pulse;

    dbuf_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .REG_W     (REG_W),
        .CNT_W     (CNT_W),
        .DEF_PERIOD(DEF_PERIOD),
        .ADDR_W    (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit_i(commit),
        .data_o  (regs_o),
        .mode_o  (mode),
        .period_o(period)
    );

    dbuf_upd_timer #(
        .CNT_W     (CNT_W),
        .DEF_PERIOD(DEF_PERIOD)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .period_i(period),
        .tick_o  (tick)
    );

    dbuf_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (upd_in),
        .rise_o(pin_rise)
    );

    // Only the source selected by the active mode may commit.
    assign commit_int = tick     && (mode == MODE_INT);
    assign commit_ext = pin_rise && (mode == MODE_EXT);
    assign commit     = commit_int | commit_ext;

    dbuf_pulse_gen #(
        .PULSE_LEN(PULSE_LEN)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (commit_int),
        .pulse_o(pulse)
    );

    assign upd_oe  = (mode == MODE_INT);
    assign upd_out = pulse & upd_oe;

    AST_EXT_IGNORES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_EXT && !pin_rise) |=> $stable(regs_o)); // R8

    AST_INT_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INT && !tick) |=> $stable(regs_o)); // R8

endmodule

// File: tb/dbuf_cfg_regs_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected values with the cycle they
// are due; a negedge monitor pops and compares them.
module dbuf_cfg_regs_bench;

    localparam int NR = 3;
    localparam int RW = 16;
    localparam int AW = 3;
    localparam int E0 = 11;   // first rising edge with rst_n high
    localparam int IX_OE  = 3;
    localparam int IX_OUT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic          upd_in = 1'b0;
    logic          upd_out;
    logic          upd_oe;
    logic [NR*RW-1:0] regs_o;

    dbuf_cfg_regs #(
        .NUM_REGS(NR), .REG_W(RW), .CNT_W(32), .DEF_PERIOD(15),
        .PULSE_LEN(8), .SYNC_STAGES(2), .ADDR_W(AW)
    ) u_dbuf_cfg_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd_in(upd_in), .upd_out(upd_out),
        .upd_oe(upd_oe), .regs_o(regs_o)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        int    idx;
        int    val;
        string tag;
    } item_t;
    item_t sb_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int obs(int idx);
        if (idx == IX_OE)  return int'(upd_oe);
        if (idx == IX_OUT) return int'(upd_out);
        return int'(regs_o[idx*RW +: RW]);
    endfunction

    // Monitor: compare every item due in this cycle, then drop it.
    always @(negedge clk) begin
        for (int k = sb_q.size() - 1; k >= 0; k--) begin
            if (sb_q[k].due == cyc) begin
                int got;
                got = obs(sb_q[k].idx);
                n_chk++;
                if (got != sb_q[k].val) begin
                    n_err++;
                    $display("FAIL %s cycle %0d item %0d: got %0h expected %0h",
                             sb_q[k].tag, cyc - E0, sb_q[k].idx, got, sb_q[k].val);
                end
                sb_q.delete(k);
            end
        end
    end

    task automatic want(int at, int idx, int val, string tag);
        sb_q.push_back('{E0 + at, idx, val, tag});
    endtask

    task automatic go_to(int at);
        while (cyc != E0 + at - 1) @(negedge clk);
    endtask

    // Write captured on edge E0+at.
    task automatic wr(int at, int a, int d);
        go_to(at);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = RW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        // Expectations (cycle offsets from E0, sampled after that edge).
        want(-1, 0, 0, "R3 reset reg0");
        want(-1, 1, 0, "R3 reset reg1");
        want(-1, 2, 0, "R3 reset reg2");
        want(-1, IX_OE, 1, "R3 reset mode internal");
        want(-1, IX_OUT, 0, "R3 reset pin low");
        want(10, 0, 0, "R1 write stays buffered");
        want(15, 0, 0, "R4 before first commit");
        want(16, 0, 'hA1, "R4 first commit at DEF_PERIOD+1");
        want(15, IX_OUT, 0, "R5 pulse not before commit");
        want(16, IX_OUT, 1, "R5 pulse starts");
        want(23, IX_OUT, 1, "R5 pulse eighth cycle");
        want(24, IX_OUT, 0, "R5 pulse ends after 8");
        want(16, 1, 0, "R9 same-edge write excluded");
        want(31, 1, 0, "R9 still old before next commit");
        want(32, 1, 'hB2, "R9 applied at next commit");
        want(41, IX_OUT, 0, "R5 pulse gap");
        want(45, 0, 'hA1, "R8 pin ignored in internal mode");
        want(47, IX_OUT, 0, "R10 old period until reload");
        want(48, 0, 'hD4, "R4 commit at 48");
        want(53, 2, 0, "R10 before short-period commit");
        want(54, 2, 'hC3, "R10 new period 5 gives commit at 54");
        want(56, IX_OUT, 1, "R5 retrigger holds pin high");
        want(59, IX_OE, 1, "R6 mode before commit");
        want(60, IX_OE, 0, "R6 external mode committed");
        want(60, IX_OUT, 0, "R6 pin drive low in external");
        want(80, 1, 'hB2, "R8 timer ignored in external mode");
        want(86, 1, 'hB2, "R7 not before third edge");
        want(87, 1, 'hE5, "R7 commit on third edge");
        want(87, IX_OUT, 0, "R6 no pulse on external commit");
        want(100, 2, 'hC3, "R7 held level no commit");
        want(110, 2, 'hC3, "R7 falling edge no commit");
        want(114, 2, 'hC3, "R7 before second rising edge");
        want(115, 2, 'hF6, "R7 second rising edge commits");
        want(124, IX_OE, 0, "R10 mode write pending");
        want(125, IX_OE, 1, "R10 mode committed by pin");
        want(125, IX_OUT, 0, "R5 no pulse for external commit");
        want(126, IX_OUT, 1, "R4 internal commit resumes");
        want(134, 0, 'hD4, "R10 period 2 not yet active");
        want(135, 0, 'h77, "R10 period 2 commit spacing");
        want(139, 0, 'h77, "R2 unused address reg0");
        want(139, 1, 'hE5, "R2 unused address reg1");
        want(139, 2, 'hF6, "R2 unused address reg2");
        want(139, IX_OE, 1, "R2 unused address mode");
        want(141, 0, 0, "R3 mid-run reset reg0");
        want(141, 1, 0, "R3 mid-run reset reg1");
        want(141, 2, 0, "R3 mid-run reset reg2");
        want(141, IX_OE, 1, "R3 mid-run reset mode");
        want(141, IX_OUT, 0, "R3 mid-run reset pin");

        // Driver.
        go_to(0);  rst_n = 1'b1;
        wr(2, 0, 'hA1);
        wr(16, 1, 'hB2);
        wr(18, 4, 5);          // period register (address NUM_REGS+1)
        wr(35, 0, 'hD4);
        go_to(37); upd_in = 1'b1;
        go_to(42); upd_in = 1'b0;
        wr(49, 2, 'hC3);
        wr(56, 3, 0);          // mode register: external
        wr(62, 1, 'hE5);
        go_to(85); upd_in = 1'b1;
        wr(90, 2, 'hF6);
        go_to(103); upd_in = 1'b0;
        go_to(113); upd_in = 1'b1;
        wr(117, 3, 1);         // back to internal
        wr(119, 4, 2);
        go_to(121); upd_in = 1'b0;
        go_to(123); upd_in = 1'b1;
        wr(133, 0, 'h77);
        wr(136, 6, 0);         // unmapped address
        go_to(141); rst_n = 1'b0;
        go_to(150);
        if (sb_q.size() != 0) begin
            n_err += sb_q.size();
            n_chk += sb_q.size();
            $display("FAIL scoreboard: %0d items never checked, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not finish, expected end by cycle %0d", E0 + 150);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule